// File: doc/BRIEF.md
# Interrupt Line Configuration Register Bank

This block is the software-visible state store for an interrupt controller that serves 32 request lines. It keeps, for every line, an enable bit, a pending bit, an active bit and an 8-bit priority field. A simple single-cycle 32-bit bus reaches this state. Enable and pending state can each be changed through a set word and a clear word, so software never needs a read-modify-write. Active state is read-only, and the priority fields sit four to a word.

Hardware requests raise pending bits. An arbiter beside the bank consumes the enable, pending and priority vectors. It reports back when it takes a line, which clears that line's pending bit and marks it active. It also reports when a handler completes, which clears the active bit. Priority fields keep only their upper `PRIO_BITS` bits; the remaining low bits are stored and read as zero, so values mean the same thing whatever width is implemented.

Top module: `irqCfgRegs`

## Requirements
- R1: A write to byte offset 0x00 sets every enable bit whose data bit is 1. A write to offset 0x04 clears every enable bit whose data bit is 1. Data bits at 0 leave the enable bit unchanged. Reads at both offsets return the enable vector, with bit i for line i.
- R2: Offsets 0x08 (set) and 0x0C (clear) act on the pending vector in the same way, and both read back the pending vector.
- R3: Priority word k sits at offset 0x20 + 4k (k = 0..7). Line 4k+j uses bits [8j+7:8j] of that word. Output `prioVec` carries line i's field at bits [8i+7:8i].
- R4: Only the upper `PRIO_BITS` bits of each priority field are stored. The low 8-`PRIO_BITS` bits are forced to zero on write and read as zero; with 3 bits the legal values are 0x00 to 0xE0 in steps of 0x20.
- R5: After reset, all enable, pending and active bits are 0, all priority fields are 0, and `busRdata` is 0.
- R6: A 1 on `hwReq[i]` sets pending bit i at the next clock edge. A `takeValid` pulse with `takeId`=i clears pending bit i and sets active bit i. A `doneValid` pulse with `doneId`=i clears active bit i. The active vector reads at offset 0x10.
- R7: If a hardware request for line i coincides with a bus clear of pending bit i, or with a take of line i, the pending bit ends up 1.
- R8: Writes to offset 0x10 and to unmapped offsets change no state. Reads from unmapped offsets return 0.
- R9: `busRdata` is registered: it carries the result of a read access one cycle after that access, reflecting state before any update in the access cycle. It is 0 after any cycle without a read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset (low two bits ignored) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| hwReq | input | 32 | Per-line hardware request |
| takeValid | input | 1 | Arbiter took a line |
| takeId | input | 5 | Line taken |
| doneValid | input | 1 | Handler for a line finished |
| doneId | input | 5 | Line finished |
| enableVec | output | 32 | Enable bits |
| pendingVec | output | 32 | Pending bits |
| prioVec | output | 256 | Priority fields |

## Verification
Every state change (enable, pending, active, priority) is registered once, so it appears on `enableVec`, `pendingVec` and `prioVec` one clock edge after the cycle that carries the write or hardware event. A bus read returns its data on `busRdata` after the edge that ends the read cycle. The bench drives all inputs just after the falling edge and samples one time unit after the following rising edge. This means each result is observed in the cycle it is due, and a read in the same cycle as a state change sees the old value.

// File: rtl/irqCfgPkg.sv
package irqCfgPkg;

  // Word offsets (byte offset >> 2)
  localparam logic [5:0] W_EN_SET   = 6'h00;
  localparam logic [5:0] W_EN_CLR   = 6'h01;
  localparam logic [5:0] W_PEND_SET = 6'h02;
  localparam logic [5:0] W_PEND_CLR = 6'h03;
  localparam logic [5:0] W_ACTIVE   = 6'h04;
  localparam logic [2:0] PRIO_PAGE  = 3'b001; // word offsets 0x08..0x0F

  typedef enum logic [2:0] {
    RD_NONE,
    RD_EN,
    RD_PEND,
    RD_ACT,
    RD_PRIO
  } rdSrcT;

  typedef struct packed {
    logic       wrEnSet;
    logic       wrEnClr;
    logic       wrPendSet;
    logic       wrPendClr;
    logic       wrPrio;
    logic [2:0] prioIdx;
    rdSrcT      rdSrc;
  } strobeT;

endpackage

// File: rtl/irqCfgCtrl.sv
module irqCfgCtrl
  import irqCfgPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output strobeT            stb
);

  logic [5:0] wordAddr;
  logic       isWrite;
  logic       isRead;
  logic       inPrio;

  assign wordAddr = busAddr[7:2];
  assign isWrite  = busSel && busWr;
  assign isRead   = busSel && !busWr;
  assign inPrio   = (wordAddr[5:3] == PRIO_PAGE);

  always_comb begin
    stb           = '0;
    stb.rdSrc     = RD_NONE;
    stb.prioIdx   = wordAddr[2:0];
    stb.wrEnSet   = isWrite && (wordAddr == W_EN_SET);
    stb.wrEnClr   = isWrite && (wordAddr == W_EN_CLR);
    stb.wrPendSet = isWrite && (wordAddr == W_PEND_SET);
    stb.wrPendClr = isWrite && (wordAddr == W_PEND_CLR);
    stb.wrPrio    = isWrite && inPrio;
    if (isRead) begin
      if (wordAddr == W_EN_SET || wordAddr == W_EN_CLR)          stb.rdSrc = RD_EN;
      else if (wordAddr == W_PEND_SET || wordAddr == W_PEND_CLR) stb.rdSrc = RD_PEND;
      else if (wordAddr == W_ACTIVE)                             stb.rdSrc = RD_ACT;
      else if (inPrio)                                           stb.rdSrc = RD_PRIO;
      else                                                       stb.rdSrc = RD_NONE;
    end
  end

endmodule

// File: rtl/irqCfgData.sv
module irqCfgData
  import irqCfgPkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int PRIO_BITS = 3,
  parameter int ID_W      = $clog2(NUM_LINES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobeT                 stb,
  input  logic [31:0]            busWdata,
  output logic [31:0]            busRdata,
  input  logic [NUM_LINES-1:0]   hwReq,
  input  logic                   takeValid,
  input  logic [ID_W-1:0]        takeId,
  input  logic                   doneValid,
  input  logic [ID_W-1:0]        doneId,
  output logic [NUM_LINES-1:0]   enableVec,
  output logic [NUM_LINES-1:0]   pendingVec,
  output logic [8*NUM_LINES-1:0] prioVec
);

  localparam int         PRIO_WORDS = NUM_LINES / 4;
  localparam logic [7:0] PRIO_MASK  = 8'(8'hFF << (8 - PRIO_BITS));

  logic [NUM_LINES-1:0] enReg, pendReg, actReg;
  logic [NUM_LINES-1:0] enNext, pendNext, actNext;
  logic [NUM_LINES-1:0] takeMask, doneMask;
  logic [NUM_LINES-1:0] wdLines;
  logic [7:0]           prioReg [NUM_LINES];
  logic [31:0]          rdMux;
  logic [31:0]          prioWord [PRIO_WORDS];

  assign wdLines  = busWdata[NUM_LINES-1:0];
  assign takeMask = takeValid ? (NUM_LINES'(1) << takeId) : '0;
  assign doneMask = doneValid ? (NUM_LINES'(1) << doneId) : '0;

  always_comb begin
    enNext = enReg;
    if (stb.wrEnSet) enNext = enNext | wdLines;
    if (stb.wrEnClr) enNext = enNext & ~wdLines;
  end

  always_comb begin
    pendNext = pendReg;
    if (stb.wrPendSet) pendNext = pendNext | wdLines;
    if (stb.wrPendClr) pendNext = pendNext & ~wdLines;
    pendNext = (pendNext & ~takeMask) | hwReq;
  end

  assign actNext = (actReg & ~doneMask) | takeMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg   <= '0;
      pendReg <= '0;
      actReg  <= '0;
    end else begin
      enReg   <= enNext;
      pendReg <= pendNext;
      actReg  <= actNext;
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_prio
    localparam int WORD = i / 4;
    localparam int LANE = i % 4;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        prioReg[i] <= '0;
      end else if (stb.wrPrio && (stb.prioIdx == 3'(WORD))) begin
        prioReg[i] <= busWdata[8*LANE +: 8] & PRIO_MASK;
      end
    end
    assign prioVec[8*i +: 8] = prioReg[i];
  end

  for (genvar w = 0; w < PRIO_WORDS; w++) begin : g_word
    assign prioWord[w] = {prioReg[4*w+3], prioReg[4*w+2], prioReg[4*w+1], prioReg[4*w]};
  end

  always_comb begin
    rdMux = '0;
    case (stb.rdSrc)
      RD_EN:   rdMux = 32'(enReg);
      RD_PEND: rdMux = 32'(pendReg);
      RD_ACT:  rdMux = 32'(actReg);
      RD_PRIO: begin
        for (int w = 0; w < PRIO_WORDS; w++) begin
          if (stb.prioIdx == 3'(w)) rdMux = prioWord[w];
        end
      end
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) busRdata <= '0;
    else       busRdata <= rdMux;
  end

  assign enableVec  = enReg;
  assign pendingVec = pendReg;

endmodule

// File: rtl/irqCfgRegs.sv
module irqCfgRegs
  import irqCfgPkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int PRIO_BITS = 3,
  parameter int ADDR_W    = 8,
  parameter int ID_W      = $clog2(NUM_LINES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busSel,
  input  logic                   busWr,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [31:0]            busWdata,
  output logic [31:0]            busRdata,
  input  logic [NUM_LINES-1:0]   hwReq,
  input  logic                   takeValid,
  input  logic [ID_W-1:0]        takeId,
  input  logic                   doneValid,
  input  logic [ID_W-1:0]        doneId,
  output logic [NUM_LINES-1:0]   enableVec,
  output logic [NUM_LINES-1:0]   pendingVec,
  output logic [8*NUM_LINES-1:0] prioVec
);

  strobeT stb;

  irqCfgCtrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .stb    (stb)
  );

  irqCfgData #(
    .NUM_LINES(NUM_LINES),
    .PRIO_BITS(PRIO_BITS),
    .ID_W     (ID_W)
  ) data_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .hwReq     (hwReq),
    .takeValid (takeValid),
    .takeId    (takeId),
    .doneValid (doneValid),
    .doneId    (doneId),
    .enableVec (enableVec),
    .pendingVec(pendingVec),
    .prioVec   (prioVec)
  );

endmodule

// File: rtl/irqCfgChk.sv
module irqCfgChk #(
  parameter int NUM_LINES = 32,
  parameter int PRIO_BITS = 3,
  parameter int ADDR_W    = 8,
  parameter int ID_W      = 5
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   busSel,
  input logic                   busWr,
  input logic [ADDR_W-1:0]      busAddr,
  input logic [31:0]            busWdata,
  input logic [NUM_LINES-1:0]   hwReq,
  input logic                   takeValid,
  input logic [ID_W-1:0]        takeId,
  input logic [NUM_LINES-1:0]   enableVec,
  input logic [NUM_LINES-1:0]   pendingVec,
  input logic [8*NUM_LINES-1:0] prioVec
);

  localparam logic [7:0] LOW_MASK = 8'(~(8'hFF << (8 - PRIO_BITS)));

  logic [8*NUM_LINES-1:0] lowAll;
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_low
    assign lowAll[8*i +: 8] = LOW_MASK;
  end

  logic [5:0] wAddr;
  logic [NUM_LINES-1:0] wd;
  assign wAddr = busAddr[7:2];
  assign wd    = busWdata[NUM_LINES-1:0];

  // R1
  a_r1_enable_set: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && wAddr == 6'h00) |=> ((enableVec & $past(wd)) == $past(wd)));

  // R1
  a_r1_enable_clear: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && wAddr == 6'h01) |=> ((enableVec & $past(wd)) == '0));

  // R4
  a_r4_low_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    ((prioVec & lowAll) == '0));

  // R6
  a_r6_take_clears: assert property (@(posedge clk) disable iff (!rstN)
    (takeValid && !hwReq[takeId]) |=> !pendingVec[$past(takeId)]);

  // R7
  a_r7_hw_wins: assert property (@(posedge clk) disable iff (!rstN)
    (|hwReq) |=> ((pendingVec & $past(hwReq)) == $past(hwReq)));

  // R8
  a_r8_active_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && wAddr == 6'h04 && hwReq == '0 && !takeValid)
      |=> ($stable(enableVec) && $stable(pendingVec) && $stable(prioVec)));

endmodule

bind irqCfgRegs irqCfgChk #(
  .NUM_LINES(NUM_LINES),
  .PRIO_BITS(PRIO_BITS),
  .ADDR_W   (ADDR_W),
  .ID_W     (ID_W)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .busSel    (busSel),
  .busWr     (busWr),
  .busAddr   (busAddr),
  .busWdata  (busWdata),
  .hwReq     (hwReq),
  .takeValid (takeValid),
  .takeId    (takeId),
  .enableVec (enableVec),
  .pendingVec(pendingVec),
  .prioVec   (prioVec)
);

// File: tb/irqCfgRegs_tb.sv
module irqCfgRegs_tb_top;

  localparam int NL = 32;
  localparam int PB = 3;
  localparam logic [7:0] PMASK = 8'(8'hFF << (8 - PB));

  logic         clk = 0;
  logic         rstN = 0;
  logic         busSel = 0, busWr = 0;
  logic [7:0]   busAddr = 0;
  logic [31:0]  busWdata = 0;
  logic [31:0]  busRdata;
  logic [31:0]  hwReq = 0;
  logic         takeValid = 0, doneValid = 0;
  logic [4:0]   takeId = 0, doneId = 0;
  logic [31:0]  enableVec, pendingVec;
  logic [255:0] prioVec;

  int checks = 0;
  int errors = 0;

  logic [31:0] expEn = 0, expPend = 0, expAct = 0;
  logic [7:0]  expPrio [NL];

  always #10 clk = ~clk;

  irqCfgRegs #(.NUM_LINES(NL), .PRIO_BITS(PB)) dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .hwReq(hwReq),
    .takeValid(takeValid), .takeId(takeId), .doneValid(doneValid), .doneId(doneId),
    .enableVec(enableVec), .pendingVec(pendingVec), .prioVec(prioVec)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: drive after falling edge, sample 1 unit after rising edge
  task automatic cyc(input logic sel, input logic wr, input logic [7:0] a, input logic [31:0] d,
                     input logic [31:0] hw, input logic tv, input logic [4:0] ti,
                     input logic dv, input logic [4:0] di);
    @(negedge clk);
    busSel = sel; busWr = wr; busAddr = a; busWdata = d;
    hwReq = hw; takeValid = tv; takeId = ti; doneValid = dv; doneId = di;
    @(posedge clk);
    #1;
    busSel = 0; busWr = 0; hwReq = 0; takeValid = 0; doneValid = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1, 1, a, d, 0, 0, 0, 0, 0);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    cyc(1, 0, a, 0, 0, 0, 0, 0, 0);
    d = busRdata;
  endtask

  function automatic logic [31:0] prioWordExp(input int k);
    return {expPrio[4*k+3], expPrio[4*k+2], expPrio[4*k+1], expPrio[4*k]};
  endfunction

  task automatic checkAllPrio(input string req);
    for (int i = 0; i < NL; i++) chk(req, 32'(prioVec[8*i +: 8]), 32'(expPrio[i]));
  endtask

  initial begin
    logic [31:0] r;
    for (int i = 0; i < NL; i++) expPrio[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    // R5: reset state
    chk("R5 rdata", busRdata, 0);
    @(negedge clk); rstN = 1;
    chk("R5 enable", enableVec, 0);
    chk("R5 pending", pendingVec, 0);
    checkAllPrio("R5 prio");
    rd(8'h10, r); chk("R5 active", r, 0);

    // R1: enable set/clear, walking one
    for (int i = 0; i < NL; i++) begin
      wr(8'h00, 32'(1) << i); expEn |= 32'(1) << i;
      chk("R1 walk set", enableVec, expEn);
    end
    wr(8'h04, 32'h0000_FFFF); expEn &= ~32'h0000_FFFF;
    chk("R1 clear", enableVec, expEn);
    wr(8'h04, 0); chk("R1 zero clear no effect", enableVec, expEn);
    wr(8'h00, 0); chk("R1 zero set no effect", enableVec, expEn);
    wr(8'h00, 32'h0000_A5A5); expEn |= 32'h0000_A5A5;
    rd(8'h00, r); chk("R1 read set word", r, expEn);
    rd(8'h04, r); chk("R1 read clear word", r, expEn);

    // R2: pending set/clear
    wr(8'h08, 32'h1234_5678); expPend = 32'h1234_5678;
    chk("R2 set", pendingVec, expPend);
    wr(8'h0C, 32'h0230_0070); expPend &= ~32'h0230_0070;
    chk("R2 clear", pendingVec, expPend);
    wr(8'h0C, 0); chk("R2 zero no effect", pendingVec, expPend);
    rd(8'h08, r); chk("R2 read set word", r, expPend);
    rd(8'h0C, r); chk("R2 read clear word", r, expPend);
    wr(8'h0C, 32'hFFFF_FFFF); expPend = 0;
    chk("R2 clear all", pendingVec, 0);

    // R3/R4: priority words with several patterns
    for (int p = 0; p < 3; p++) begin
      for (int k = 0; k < NL/4; k++) begin
        logic [31:0] d;
        d = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? (32'h1F2E_3D4C ^ (32'(k) * 32'h0101_0101))
                                    : (32'h8040_2010 + 32'(k) * 32'h1111_1111);
        wr(8'h20 + 8'(4*k), d);
        for (int j = 0; j < 4; j++) expPrio[4*k+j] = d[8*j +: 8] & PMASK;
        rd(8'h20 + 8'(4*k), r);
        chk("R3 R4 prio word readback", r, prioWordExp(k));
      end
      checkAllPrio("R3 prioVec layout");
    end
    // R4: exhaustive sweep of one field over every byte value
    for (int v = 0; v < 256; v++) begin
      wr(8'h34, {8'h00, 8'h00, 8'(v), 8'h00}); // line 21 = word 5 lane 1
      expPrio[20] = 0; expPrio[21] = 8'(v) & PMASK; expPrio[22] = 0; expPrio[23] = 0;
      chk("R4 masked field", 32'(prioVec[8*21 +: 8]), 32'(8'(v) & PMASK));
    end

    // R6: hardware request, take, done
    cyc(0, 0, 0, 0, 32'h0000_0020, 0, 0, 0, 0); expPend |= 32'h20;
    chk("R6 hwReq sets pending", pendingVec, expPend);
    cyc(0, 0, 0, 0, 0, 1, 5'd5, 0, 0); expPend &= ~32'h20; expAct |= 32'h20;
    chk("R6 take clears pending", pendingVec, expPend);
    rd(8'h10, r); chk("R6 take sets active", r, expAct);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 5'd5); expAct &= ~32'h20;
    rd(8'h10, r); chk("R6 done clears active", r, expAct);

    // R7: hw set beats sw clear and take
    cyc(1, 1, 8'h0C, 32'h0000_0200, 32'h0000_0200, 0, 0, 0, 0); expPend |= 32'h200;
    chk("R7 hw over sw clear", pendingVec, expPend);
    cyc(0, 0, 0, 0, 32'h0000_0200, 1, 5'd9, 0, 0); expAct |= 32'h200;
    chk("R7 hw over take", pendingVec, expPend);

    // R8: ignored writes and unmapped reads
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, r); chk("R8 active write ignored", r, expAct);
    wr(8'h14, 32'hFFFF_FFFF); wr(8'h40, 32'hFFFF_FFFF); wr(8'hFC, 32'hFFFF_FFFF);
    chk("R8 enable unchanged", enableVec, expEn);
    chk("R8 pending unchanged", pendingVec, expPend);
    checkAllPrio("R8 prio unchanged");
    rd(8'h14, r); chk("R8 unmapped read 0x14", r, 0);
    rd(8'h80, r); chk("R8 unmapped read 0x80", r, 0);

    // R9: registered read, old value on same-cycle write, zero when idle
    rd(8'h00, r);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R9 idle gives zero", busRdata, 0);
    cyc(1, 0, 8'h08, 0, 32'h0000_0001, 0, 0, 0, 0);
    chk("R9 read sees pre-update state", busRdata, expPend);
    expPend |= 1;
    chk("R9 update lands same edge", pendingVec, expPend);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule